// File: doc/BRIEF.md
# Memory Access Wait-State Generator

This block sits beside the memory path of an 8-bit processor and lengthens memory cycles without touching the processor clock. When the active-low memory-request strobe falls, the block sorts the cycle into one of three kinds from the status strobes. The kinds are an instruction fetch (fetch marker and read strobe both low), a data read (read strobe low, fetch marker high) and a write (write strobe low). From the kind and two configuration registers it works out how many extra clocks the cycle needs. It then holds its active-low wait output low for exactly that many clocks.

Two 8-bit registers hold the policy. The arming register has an enable bit. While that bit is clear, no cycle is stretched. While it is set, the block stretches every write. Fetches are stretched only when a fetch-enable bit is set in the policy register, and data reads only when a read-enable bit is set. Cycles in which the I/O request strobe is low are never stretched. Each stretch lasts EXTRA_CLKS clocks. The configuration in force is captured when a cycle starts, so a register write made while a stretch runs applies from the next request.

Top module: `memwait_gen`

## Requirements
- R1: After reset the policy register reads 0x44 and the arming register reads 0x14. With these values no cycle of any kind is stretched.
- R2: A write on the register port stores all 8 bits into the register chosen by `reg_sel` (0 = policy, 1 = arming). `reg_rdata` shows the full 8-bit value of the selected register one clock after `reg_sel` is applied.
- R3: With arming bit 1 set, a write cycle (`wr_n` low) is stretched by EXTRA_CLKS clocks, whatever the values of policy bits 4 and 5.
- R4: With arming bit 1 set, an instruction fetch (`m1_n` and `rd_n` both low) is stretched by EXTRA_CLKS clocks when policy bit 4 is 1, and by 0 clocks when policy bit 4 is 0.
- R5: With arming bit 1 set, a data read (`rd_n` low, `m1_n` high) is stretched by EXTRA_CLKS clocks when policy bit 5 is 1, and by 0 clocks when policy bit 5 is 0.
- R6: With arming bit 1 clear, no memory cycle drives `wait_n` low, whatever the policy register holds.
- R7: A cycle in which `iorq_n` is low when the request starts is never stretched.
- R8: A request starts on the first rising clock edge that samples `mreq_n` low after sampling it high. From that edge `wait_n` stays low for exactly the computed number of clocks and then returns high. When the computed number is zero, `wait_n` stays high.
- R9: A register write made while a stretch is running leaves that stretch's length unchanged. The next request uses the new value.
- R10: A synchronous active-high reset, asserted at any time, returns both registers to 0x44 and 0x14.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mreq_n | input | 1 | Memory request strobe, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| m1_n | input | 1 | Instruction fetch marker, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| reg_we | input | 1 | Register write enable |
| reg_sel | input | 1 | Register select: 0 policy, 1 arming |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Selected register value, registered |
| wait_n | output | 1 | Wait request to the processor, active low, registered |

## Verification
The bench builds the block with EXTRA_CLKS set to 3. This gives a two-bit down-counter, so a miscounted stretch of 1, 2 or 4 clocks is told apart from the correct 3, and each stretch has clocks in the middle where a configuration write can be made. With the default of 1, a stretch is a single clock and the "exactly N clocks" and mid-stretch write cases cannot be seen.

// File: rtl/memwait_pkg.sv
package memwait_pkg;
  typedef enum logic [1:0] {
    CYC_NONE  = 2'd0,
    CYC_FETCH = 2'd1,
    CYC_READ  = 2'd2,
    CYC_WRITE = 2'd3
  } cyc_t;

  localparam int REG_W = 8;
  localparam logic [REG_W-1:0] POLICY_RST = 8'h44;
  localparam logic [REG_W-1:0] ARM_RST    = 8'h14;
  localparam int FETCH_EN_BIT = 4;
  localparam int READ_EN_BIT  = 5;
  localparam int ARM_BIT      = 1;
endpackage

// File: rtl/memwait_regs.sv
module memwait_regs
  import memwait_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic [REG_W-1:0] policy_q,
  output logic [REG_W-1:0] arm_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      policy_q  <= POLICY_RST;
      arm_q     <= ARM_RST;
      reg_rdata <= '0;
    end else begin
      if (reg_we && !reg_sel) policy_q <= reg_wdata;
      if (reg_we &&  reg_sel) arm_q    <= reg_wdata;
      reg_rdata <= reg_sel ? arm_q : policy_q;
    end
  end

  AST_RESET_DEFAULTS: assert property (@(posedge clk)
    rst |=> (policy_q == POLICY_RST && arm_q == ARM_RST)); // R10

  AST_WRITE_STORES: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_sel) |=> (arm_q == $past(reg_wdata))); // R2
endmodule

// File: rtl/memwait_classify.sv
module memwait_classify
  import memwait_pkg::*;
#(
  parameter int EXTRA_CLKS = 1,
  parameter int CNT_W      = 1
) (
  input  logic             m1_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             iorq_n,
  input  logic [REG_W-1:0] policy_q,
  input  logic [REG_W-1:0] arm_q,
  output cyc_t             cyc_type,
  output logic [CNT_W-1:0] extra
);
  localparam logic [CNT_W-1:0] EXTRA_V = CNT_W'(EXTRA_CLKS);

  always_comb begin
    if (!iorq_n)                cyc_type = CYC_NONE;
    else if (!wr_n)             cyc_type = CYC_WRITE;
    else if (!rd_n && !m1_n)    cyc_type = CYC_FETCH;
    else if (!rd_n)             cyc_type = CYC_READ;
    else                        cyc_type = CYC_NONE;
  end

  logic stretch;
  always_comb begin
    case (cyc_type)
      CYC_WRITE: stretch = 1'b1;
      CYC_FETCH: stretch = policy_q[FETCH_EN_BIT];
      CYC_READ:  stretch = policy_q[READ_EN_BIT];
      default:   stretch = 1'b0;
    endcase
    extra = (stretch && arm_q[ARM_BIT]) ? EXTRA_V : '0;
  end
endmodule

// File: rtl/memwait_stretch.sv
module memwait_stretch #(
  parameter int CNT_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mreq_n,
  input  logic [CNT_W-1:0] load_val,
  output logic             start,
  output logic             wait_n
);
  logic             mreq_q;
  logic [CNT_W-1:0] cnt, cnt_nx;

  assign start = mreq_q && !mreq_n;

  always_comb begin
    if (start)          cnt_nx = load_val;
    else if (cnt != '0) cnt_nx = cnt - CNT_W'(1);
    else                cnt_nx = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mreq_q <= 1'b1;
      cnt    <= '0;
      wait_n <= 1'b1;
    end else begin
      mreq_q <= mreq_n;
      cnt    <= cnt_nx;
      wait_n <= (cnt_nx == '0);
    end
  end

  AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
    (start && load_val != '0) |=> !wait_n); // R8

  AST_ZERO_HIGH: assert property (@(posedge clk) disable iff (rst)
    (start && load_val == '0) |=> wait_n); // R8

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!start && wait_n) |=> wait_n); // R8
endmodule

// File: rtl/memwait_gen.sv
module memwait_gen
  import memwait_pkg::*;
#(
  parameter int EXTRA_CLKS = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mreq_n,
  input  logic       iorq_n,
  input  logic       m1_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic       reg_we,
  input  logic       reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       wait_n
);
  localparam int CNT_W = $clog2(EXTRA_CLKS + 1);

  logic [REG_W-1:0] policy_q, arm_q;
  cyc_t             cyc_type;
  logic [CNT_W-1:0] extra;
  logic             start;

  memwait_regs u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .policy_q(policy_q), .arm_q(arm_q)
  );

  memwait_classify #(.EXTRA_CLKS(EXTRA_CLKS), .CNT_W(CNT_W)) u_cls (
    .m1_n(m1_n), .rd_n(rd_n), .wr_n(wr_n), .iorq_n(iorq_n),
    .policy_q(policy_q), .arm_q(arm_q),
    .cyc_type(cyc_type), .extra(extra)
  );

  memwait_stretch #(.CNT_W(CNT_W)) u_str (
    .clk(clk), .rst(rst), .mreq_n(mreq_n), .load_val(extra),
    .start(start), .wait_n(wait_n)
  );

  AST_IO_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
    (start && !iorq_n) |=> wait_n); // R7

  AST_DISARMED_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
    (start && !arm_q[ARM_BIT]) |=> wait_n); // R6

  AST_WRITE_WAITS: assert property (@(posedge clk) disable iff (rst)
    (start && iorq_n && !wr_n && arm_q[ARM_BIT]) |=> !wait_n); // R3
endmodule

// File: tb/memwait_gen_bench.sv
`timescale 1ns/1ps
module memwait_gen_bench;
  localparam int EXTRA = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mreq_n = 1'b1, iorq_n = 1'b1, m1_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic reg_we = 1'b0, reg_sel = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic wait_n;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mdl_pol = 8'h44;
  logic [7:0] mdl_arm = 8'h14;

  always #5 clk = ~clk;

  memwait_gen #(.EXTRA_CLKS(EXTRA)) u_memwait_gen (
    .clk(clk), .rst(rst), .mreq_n(mreq_n), .iorq_n(iorq_n), .m1_n(m1_n),
    .rd_n(rd_n), .wr_n(wr_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wait_n(wait_n)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // kind: 0 fetch, 1 data read, 2 write, 3 io-qualified
  function automatic int exp_len(logic [7:0] pol, logic [7:0] arm, int kind);
    if (!arm[1]) return 0;
    case (kind)
      0: return pol[4] ? EXTRA : 0;
      1: return pol[5] ? EXTRA : 0;
      2: return EXTRA;
      default: return 0;
    endcase
  endfunction

  task automatic reg_write(logic sel, logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (sel) mdl_arm = d; else mdl_pol = d;
  endtask

  task automatic reg_read(logic sel, output logic [7:0] v);
    @(negedge clk);
    reg_sel = sel;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic drive_kind(int kind);
    mreq_n = 1'b0;
    case (kind)
      0: begin m1_n = 1'b0; rd_n = 1'b0; end
      1: rd_n = 1'b0;
      2: wr_n = 1'b0;
      default: begin iorq_n = 1'b0; rd_n = 1'b0; end
    endcase
  endtask

  task automatic release_bus();
    mreq_n = 1'b1; iorq_n = 1'b1; m1_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic run_cycle(int kind, output int lows, output int first_low);
    @(negedge clk);
    drive_kind(kind);
    lows = 0; first_low = 0;
    for (int i = 0; i < EXTRA + 3; i++) begin
      @(negedge clk);
      if (i == 0) first_low = int'(!wait_n);
      if (!wait_n) lows++;
    end
    release_bus();
    @(negedge clk);
  endtask

  task automatic test_cycle(string req, int kind);
    int lows, first, e;
    e = exp_len(mdl_pol, mdl_arm, kind);
    run_cycle(kind, lows, first);
    check(req, lows, e);
    check({req, " start"}, first, (e != 0) ? 1 : 0);
    check("R8 idle high", int'(wait_n), 1);
  endtask

  initial begin
    #1ms;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int lows, first;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: defaults
    reg_read(1'b0, v); check("R1 policy reset", v, 8'h44);
    reg_read(1'b1, v); check("R1 arming reset", v, 8'h14);
    check("R1 wait idle", int'(wait_n), 1);
    for (int k = 0; k < 4; k++) test_cycle("R1 default no stretch", k);

    // R2: full-width readback
    reg_write(1'b0, 8'hA5); reg_read(1'b0, v); check("R2 policy rb", v, 8'hA5);
    reg_write(1'b1, 8'h5A); reg_read(1'b1, v); check("R2 arming rb", v, 8'h5A);

    // R3: write stretched regardless of bits 4/5
    reg_write(1'b1, 8'h16);
    reg_write(1'b0, 8'h44); test_cycle("R3 write pol44", 2);
    reg_write(1'b0, 8'h00); test_cycle("R3 write pol00", 2);
    // R4 fetch enable
    test_cycle("R4 fetch bit4=0", 0);
    reg_write(1'b0, 8'h10); test_cycle("R4 fetch bit4=1", 0);
    test_cycle("R5 read bit5=0", 1);
    // R5 read enable
    reg_write(1'b0, 8'h20); test_cycle("R5 read bit5=1", 1);
    test_cycle("R4 fetch off with bit5", 0);
    reg_write(1'b0, 8'h74);
    test_cycle("R4 fetch pol74", 0);
    test_cycle("R5 read pol74", 1);
    // R7 io never stretched
    test_cycle("R7 io", 3);
    // R6 disarmed
    reg_write(1'b0, 8'hFF); reg_write(1'b1, 8'hFD);
    for (int k = 0; k < 3; k++) test_cycle("R6 disarmed", k);

    // R9: write during stretch
    reg_write(1'b1, 8'h02);
    @(negedge clk);
    drive_kind(2);
    lows = 0;
    for (int i = 0; i < EXTRA + 3; i++) begin
      @(negedge clk);
      if (i == 0) begin reg_we = 1'b1; reg_sel = 1'b1; reg_wdata = 8'h00; end
      else reg_we = 1'b0;
      if (!wait_n) lows++;
    end
    mdl_arm = 8'h00;
    release_bus();
    @(negedge clk);
    check("R9 stretch kept", lows, EXTRA);
    test_cycle("R9 next uses new", 2);

    // random mix
    for (int n = 0; n < 60; n++) begin
      int k;
      if ($urandom_range(0, 2) == 0) reg_write(1'b0, 8'($urandom_range(0, 255)));
      if ($urandom_range(0, 2) == 0) reg_write(1'b1, 8'($urandom_range(0, 255)));
      k = $urandom_range(0, 3);
      case (k)
        0: test_cycle("R4 random", k);
        1: test_cycle("R5 random", k);
        2: test_cycle("R3 random", k);
        default: test_cycle("R7 random", k);
      endcase
    end

    // R10: reset mid-run
    reg_write(1'b0, 8'h3C); reg_write(1'b1, 8'hC3);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    mdl_pol = 8'h44; mdl_arm = 8'h14;
    reg_read(1'b0, v); check("R10 policy", v, 8'h44);
    reg_read(1'b1, v); check("R10 arming", v, 8'h14);
    test_cycle("R10 write after reset", 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule